// File: doc/BRIEF.md
# Diamond Shift-Add 5x5 Smoothing Filter

This block smooths a raster stream of unsigned image samples with a fixed 5x5 kernel whose nonzero weights form a diamond around the centre. Every weight is a power of two, so each product is a right shift of a tap. The shifted taps are added with seven fraction bits kept, and the sum is truncated once at the end. The block has no multipliers. Samples arrive one per valid cycle, with a start-of-frame and a start-of-line marker. The line width and frame height are parameters.

Four line buffers and a 5x5 register window hold the neighbourhood of the pixel two rows and two columns behind the newest sample. The block produces one filtered sample for every accepted input once the window holds real data. It therefore drives no output for the first `2*IMG_W+2` samples after the first start-of-frame. Pixels within two of an image edge are still produced. A parameter selects how missing taps are filled: by repeating the nearest edge pixel, or with zeros. The last two rows of a frame leave the block while the next frame's first rows are entering it.

A start-of-line marker on a sample that is not in column 0 forces that sample to column 0 of the next row.

Top module: `diamond_smooth5`

## Requirements
- R1: While `rst_n` is low, and on the first clock edges after it rises, `out_valid`, `out_sof` and `out_sol` are 0. `out_valid` stays 0 for the first `2*IMG_W+2` valid samples counted from the first `in_sof`.
- R2: For a centre at least two pixels from every edge, the output is a weighted sum of the taps, each tap being an unsigned `DW`-bit sample. The weights are: centre 1/8; the four taps one step along a row or column 1/64; the four diagonal neighbours 1/128; the four taps two steps along a row or column 1/128; the other twelve positions 0.
- R3: The weighted sum is formed exactly, in units of 1/128, and is truncated toward zero only once, to `DW` bits. A frame of all-maximum samples therefore gives `(2**DW-1)>>2` at every pixel in replicate mode, with no overflow.
- R4: With `BORDER = BORDER_REPLICATE`, a tap whose row or column lies outside the frame takes the value at the row and column clamped into the frame.
- R5: With `BORDER = BORDER_ZERO`, a tap whose row or column lies outside the frame counts as 0.
- R6: The output for the centre at stream index k (counted from the first `in_sof`) appears with `out_valid` high exactly two clock cycles after the `in_valid` cycle of sample k+2*IMG_W+2.
- R7: `out_sof` is 1 exactly on the output for row 0, column 0. `out_sol` is 1 exactly on outputs for column 0. Both are 0 when `out_valid` is 0.
- R8: Samples accepted before the first `in_sof` after reset never produce an output. Counting and positions start at the first `in_sof`.
- R9: A cycle with `in_valid` low does not advance the pipeline, and it is followed two cycles later by a cycle with `out_valid` low.
- R10: Over a run of N samples from the first `in_sof`, exactly N-(2*IMG_W+2) outputs are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sof | input | 1 | Sample is row 0, column 0 of a frame |
| in_sol | input | 1 | Sample is column 0 of a row |
| in_data | input | DW | Unsigned input sample |
| out_valid | output | 1 | Output sample strobe |
| out_sof | output | 1 | Output is row 0, column 0 |
| out_sol | output | 1 | Output is column 0 |
| out_data | output | DW | Filtered sample |

## Verification
The bench runs one instance in each border mode on a small frame. It streams five consecutive frames: all-maximum, a ramp, a scrambled pattern and a checkerboard, followed by a zero frame that drains the pipeline. Every output pixel is compared against an arithmetic model.

The two centre columns and rows nearest each edge are the key cases. A remap that is off by one would blend pixels from the wrapped row or from the neighbouring frame into edge outputs. The all-maximum frame would expose an adder that is too narrow, or an early truncation of the 1/128 taps, as a wrong or wrapped result.

Junk samples before the first start-of-frame and idle gaps inside frames probe the priming count. An off-by-one there would shift every output by one pixel or emit outputs during gaps. Marker checks on each output catch a window-centre coordinate that is off by one position.

// File: rtl/diamond_pkg.sv
// Package: shared types for the diamond smoothing filter.
// Assumes nothing beyond IEEE 1800-2017.
package diamond_pkg;

    // Border policy for taps that fall outside the frame
    typedef enum logic [0:0] {
        BORDER_REPLICATE = 1'b0,
        BORDER_ZERO      = 1'b1
    } border_e;

    // Window size and fraction bits kept in the accumulator
    localparam int WIN  = 5;
    localparam int FRAC = 7;

endpackage

// File: rtl/diamond_linebuf.sv
// Module: delay line of exactly DEPTH enabled samples.
// Purpose: holds one image row so that the tap one row above is available.
// Assumes: read happens before write in the same cycle (combinational read).
module diamond_linebuf #(
    parameter int DW    = 8,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] ptr;

    // Oldest stored sample sits at the pointer
    assign dout = mem[ptr];

    // Circular pointer advances on each accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (en) begin
            ptr <= (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
        end
    end

    // Storage is written in place of the sample just read
    always_ff @(posedge clk) begin
        if (en) begin
            mem[ptr] <= din;
        end
    end
endmodule

// File: rtl/diamond_raster_track.sv
// Module: tracks the raster position of the incoming sample and derives the
// position of the window centre, two rows and two columns behind it.
// Assumes: IMG_W >= 3, IMG_H >= 3, frames arrive back to back.
// Counting starts at the first start-of-frame after reset.
module diamond_raster_track #(
    parameter int IMG_W = 64,
    parameter int IMG_H = 48,
    localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1,
    localparam int RW = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_sol,
    output logic [RW-1:0] ctr_row,
    output logic [CW-1:0] ctr_col,
    output logic          ctr_live
);
    localparam int PRIME = 2 * IMG_W + 2;
    localparam int PCW   = $clog2(PRIME + 1);

    logic [CW-1:0]  nxt_col, cur_col;
    logic [RW-1:0]  nxt_row, cur_row;
    logic           seen;
    logic [PCW-1:0] cnt, cnt_now;

    // Position of the sample on the input, after marker realignment
    always_comb begin
        cur_col = nxt_col;
        cur_row = nxt_row;
        if (in_sof) begin
            cur_col = '0;
            cur_row = '0;
        end else if (in_sol && nxt_col != '0) begin
            cur_col = '0;
            cur_row = (nxt_row == RW'(IMG_H - 1)) ? '0 : nxt_row + 1'b1;
        end
    end

    // Centre position: stream index minus 2*IMG_W+2, wrapped in the frame
    always_comb begin
        int c, r;
        c = int'(cur_col) - 2;
        r = int'(cur_row) - 2;
        if (c < 0) begin
            c = c + IMG_W;
            r = r - 1;
        end
        if (r < 0) begin
            r = r + IMG_H;
        end
        ctr_col = CW'(c);
        ctr_row = RW'(r);
    end

    // Centre is real once enough samples have followed the first frame start
    assign cnt_now  = seen ? cnt : '0;
    assign ctr_live = (seen || in_sof) && (cnt_now >= PCW'(PRIME));

    // Position and priming counters advance on accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_col <= '0;
            nxt_row <= '0;
            seen    <= 1'b0;
            cnt     <= '0;
        end else if (in_valid) begin
            if (cur_col == CW'(IMG_W - 1)) begin
                nxt_col <= '0;
                nxt_row <= (cur_row == RW'(IMG_H - 1)) ? '0 : cur_row + 1'b1;
            end else begin
                nxt_col <= cur_col + 1'b1;
                nxt_row <= cur_row;
            end
            if (seen || in_sof) begin
                seen <= 1'b1;
                if (cnt_now < PCW'(PRIME)) begin
                    cnt <= cnt_now + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/diamond_tap_select.sv
// Module: applies the border policy to the raw 5x5 window.
// Purpose: the raw window holds the stream linearly, so taps past an edge
// hold pixels from a wrapped row or another frame. This module replaces them.
// Assumes: win[i][j] holds the offset (i-2 rows, j-2 columns) from the centre.
module diamond_tap_select
    import diamond_pkg::*;
#(
    parameter int      DW     = 8,
    parameter int      IMG_W  = 64,
    parameter int      IMG_H  = 48,
    parameter border_e BORDER = BORDER_REPLICATE,
    localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1,
    localparam int RW = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
    input  logic [DW-1:0] win [WIN][WIN],
    input  logic [RW-1:0] ctr_row,
    input  logic [CW-1:0] ctr_col,
    output logic [DW-1:0] eff [WIN][WIN]
);
    // Window index that holds the clamped position along one axis
    function automatic int clamp_idx(int k, int ctr, int lim);
        int p;
        p = ctr + k - 2;
        if (p < 0)       return 2 - ctr;
        if (p > lim - 1) return 2 + (lim - 1) - ctr;
        return k;
    endfunction

    // Whether the position along one axis lies inside the frame
    function automatic bit in_range(int k, int ctr, int lim);
        int p;
        p = ctr + k - 2;
        return (p >= 0) && (p < lim);
    endfunction

    generate
        if (BORDER == BORDER_REPLICATE) begin : g_replicate
            // Replicate: each outside tap reads the nearest edge pixel
            always_comb begin
                for (int i = 0; i < WIN; i++) begin
                    for (int j = 0; j < WIN; j++) begin
                        eff[i][j] = win[clamp_idx(i, int'(ctr_row), IMG_H)]
                                       [clamp_idx(j, int'(ctr_col), IMG_W)];
                    end
                end
            end
        end else begin : g_zero
            // Zero: each outside tap is forced to zero
            always_comb begin
                for (int i = 0; i < WIN; i++) begin
                    for (int j = 0; j < WIN; j++) begin
                        eff[i][j] = (in_range(i, int'(ctr_row), IMG_H) &&
                                     in_range(j, int'(ctr_col), IMG_W))
                                    ? win[i][j] : '0;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/diamond_sum.sv
// Module: shift-add evaluation of the diamond kernel.
// Purpose: each nonzero weight 2^-s is applied as a scale by 2^(FRAC-s).
// The sum is exact in units of 2^-FRAC and is truncated once at the end.
// Assumes: unsigned taps; the weights add to 1/4, so the result fits DW bits.
module diamond_sum
    import diamond_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] eff [WIN][WIN],
    output logic [DW-1:0] result
);
    localparam int AW = DW + FRAC;

    // Shift amount for one window offset; 0 marks an unused position
    function automatic int shift_of(int dy, int dx);
        int ay, ax;
        ay = (dy < 0) ? -dy : dy;
        ax = (dx < 0) ? -dx : dx;
        if (ay + ax == 0)                         return 3;
        if (ay + ax == 1)                         return 6;
        if (ay == 1 && ax == 1)                   return 7;
        if (ay + ax == 2 && (ay == 0 || ax == 0)) return 7;
        return 0;
    endfunction

    logic [AW-1:0] acc;

    // Exact fixed-point sum of all weighted taps
    always_comb begin
        acc = '0;
        for (int i = 0; i < WIN; i++) begin
            for (int j = 0; j < WIN; j++) begin
                if (shift_of(i - 2, j - 2) != 0) begin
                    acc = acc + (AW'(eff[i][j]) << (FRAC - shift_of(i - 2, j - 2)));
                end
            end
        end
    end

    // Single truncation toward zero to the sample width
    assign result = acc[FRAC +: DW];
endmodule

// File: rtl/diamond_smooth5.sv
// Module: streaming 5x5 diamond smoothing filter, top level.
// Purpose: four line buffers feed a 5x5 window. The border policy remaps the
// edge taps and a shift-add tree forms the output.
// Timing: the centre at stream index k leaves two cycles after the valid of
// sample k + LAT_SAMPLES. Each stage advances only on in_valid.
// Assumes: IMG_W >= 3, IMG_H >= 3, frames of exactly IMG_W x IMG_H samples.
module diamond_smooth5
    import diamond_pkg::*;
#(
    parameter int      DW     = 8,
    parameter int      IMG_W  = 64,
    parameter int      IMG_H  = 48,
    parameter border_e BORDER = BORDER_REPLICATE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_sol,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic          out_sof,
    output logic          out_sol,
    output logic [DW-1:0] out_data
);
    localparam int CW          = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int RW          = (IMG_H > 1) ? $clog2(IMG_H) : 1;
    localparam int NLB         = WIN - 1;
    localparam int LAT_SAMPLES = 2 * IMG_W + 2;
    localparam int LAT_CYCLES  = 2;

    logic [DW-1:0] lb_out  [NLB];
    logic [DW-1:0] col_tap [WIN];
    logic [DW-1:0] win     [WIN][WIN];
    logic [DW-1:0] eff     [WIN][WIN];
    logic [DW-1:0] sum_val;
    logic [RW-1:0] ctr_row, row_q;
    logic [CW-1:0] ctr_col, col_q;
    logic          ctr_live;
    logic          v1, sof1, sol1;

    // Raster position and priming
    diamond_raster_track #(
        .IMG_W(IMG_W),
        .IMG_H(IMG_H)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_sof  (in_sof),
        .in_sol  (in_sol),
        .ctr_row (ctr_row),
        .ctr_col (ctr_col),
        .ctr_live(ctr_live)
    );

    // Chain of line buffers: buffer k delays the stream by (k+1) rows
    generate
        for (genvar k = 0; k < NLB; k++) begin : g_lb
            diamond_linebuf #(
                .DW   (DW),
                .DEPTH(IMG_W)
            ) u_lb (
                .clk  (clk),
                .rst_n(rst_n),
                .en   (in_valid),
                .din  ((k == 0) ? in_data : lb_out[(k == 0) ? 0 : k - 1]),
                .dout (lb_out[k])
            );
            assign col_tap[WIN - 2 - k] = lb_out[k];
        end
    endgenerate
    assign col_tap[WIN - 1] = in_data;

    // Window shift and centre coordinates, stage one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            sof1  <= 1'b0;
            sol1  <= 1'b0;
            row_q <= '0;
            col_q <= '0;
            for (int i = 0; i < WIN; i++) begin
                for (int j = 0; j < WIN; j++) begin
                    win[i][j] <= '0;
                end
            end
        end else begin
            v1 <= in_valid && ctr_live;
            if (in_valid) begin
                row_q <= ctr_row;
                col_q <= ctr_col;
                sof1  <= (ctr_row == '0) && (ctr_col == '0);
                sol1  <= (ctr_col == '0);
                for (int i = 0; i < WIN; i++) begin
                    for (int j = 0; j < WIN - 1; j++) begin
                        win[i][j] <= win[i][j + 1];
                    end
                    win[i][WIN - 1] <= col_tap[i];
                end
            end
        end
    end

    // Border remap of the registered window
    diamond_tap_select #(
        .DW    (DW),
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .BORDER(BORDER)
    ) u_sel (
        .win    (win),
        .ctr_row(row_q),
        .ctr_col(col_q),
        .eff    (eff)
    );

    // Shift-add kernel
    diamond_sum #(
        .DW(DW)
    ) u_sum (
        .eff   (eff),
        .result(sum_val)
    );

    // Output register, stage two
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_sol   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= v1;
            out_sof   <= v1 && sof1;
            out_sol   <= v1 && sol1;
            if (v1) begin
                out_data <= sum_val;
            end
        end
    end
endmodule

// File: rtl/diamond_smooth5_chk.sv
// Module: assertion checker for diamond_smooth5, attached by bind.
// Purpose: checks the output protocol, the priming delay and the output bound.
module diamond_smooth5_chk #(
    parameter int DW    = 8,
    parameter int IMG_W = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sof,
    input logic          out_valid,
    input logic          out_sof,
    input logic          out_sol,
    input logic [DW-1:0] out_data
);
    localparam int PRIME = 2 * IMG_W + 2;
    localparam int KW    = $clog2(PRIME + 2);
    localparam logic [DW-1:0] LIMIT = {2'b00, {(DW - 2){1'b1}}};

    logic          seen;
    logic [KW-1:0] cnt;

    // Independent count of samples since the first start-of-frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
            cnt  <= '0;
        end else if (in_valid && (seen || in_sof)) begin
            seen <= 1'b1;
            if (cnt < KW'(PRIME + 1)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R1 R8: no output before the window is primed
    p_primed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cnt >= KW'(PRIME + 1)));

    // R9: every output comes from a valid input two cycles earlier
    p_out_from_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R7: markers only on valid outputs
    p_sof_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    p_sol_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);

    // R7: frame start is also a line start
    p_sof_is_sol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_sol);

    // R3: weights sum to one quarter, so no result exceeds max/4
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data <= LIMIT));
endmodule

bind diamond_smooth5 diamond_smooth5_chk #(
    .DW   (DW),
    .IMG_W(IMG_W)
) u_chk (.*);

// File: tb/diamond_smooth5_bench.sv
`timescale 1ns/1ps
module diamond_smooth5_bench;
    import diamond_pkg::*;

    localparam int DW    = 8;
    localparam int W     = 8;
    localparam int H     = 6;
    localparam int NF    = 5;
    localparam int PRIME = 2 * W + 2;
    localparam int MAXV  = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic          in_sol = 1'b0;
    logic [DW-1:0] in_data = '0;

    logic          rv, rsof, rsol;
    logic [DW-1:0] rdata;
    logic          zv, zsof, zsol;
    logic [DW-1:0] zdata;

    int n_tests = 0;
    int n_fail  = 0;
    int n_out   = 0;
    int n_in    = 0;
    bit done    = 0;

    // History of what was driven one and two negedges ago
    bit h0_v = 0, h1_v = 0;
    int h0_i = -1, h1_i = -1;
    int next_idx = -1;

    always #2 clk = ~clk;

    diamond_smooth5 #(
        .DW(DW), .IMG_W(W), .IMG_H(H), .BORDER(BORDER_REPLICATE)
    ) u_diamond_smooth5 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_data(in_data), .out_valid(rv), .out_sof(rsof),
        .out_sol(rsol), .out_data(rdata)
    );

    diamond_smooth5 #(
        .DW(DW), .IMG_W(W), .IMG_H(H), .BORDER(BORDER_ZERO)
    ) u_diamond_smooth5_zero (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_data(in_data), .out_valid(zv), .out_sof(zsof),
        .out_sol(zsol), .out_data(zdata)
    );

    // Test image for frame f
    function automatic int pix(int f, int r, int c);
        case (f)
            0:       return MAXV;
            1:       return ((r * W + c) * 5) % 256;
            2:       return ((r * 37 + c * 101 + 13) ^ (r * c * 7)) % 256;
            3:       return ((r + c) % 2 == 1) ? MAXV : 0;
            default: return 0;
        endcase
    endfunction

    // Weight numerator in units of 1/128
    function automatic int wnum(int dy, int dx);
        int ay, ax;
        ay = (dy < 0) ? -dy : dy;
        ax = (dx < 0) ? -dx : dx;
        if (ay + ax == 0) return 16;
        if (ay + ax == 1) return 2;
        if (ay == 1 && ax == 1) return 1;
        if (ay + ax == 2 && (ay == 0 || ax == 0)) return 1;
        return 0;
    endfunction

    // Reference output for one pixel under one border policy
    function automatic int ref_out(int f, int r, int c, bit zero_mode);
        int acc;
        acc = 0;
        for (int dy = -2; dy <= 2; dy++) begin
            for (int dx = -2; dx <= 2; dx++) begin
                int rr, cc, v;
                rr = r + dy;
                cc = c + dx;
                if (rr < 0 || rr >= H || cc < 0 || cc >= W) begin
                    if (zero_mode) v = 0;
                    else v = pix(f, (rr < 0) ? 0 : (rr >= H ? H - 1 : rr),
                                    (cc < 0) ? 0 : (cc >= W ? W - 1 : cc));
                end else begin
                    v = pix(f, rr, cc);
                end
                acc += wnum(dy, dx) * v;
            end
        end
        return acc / 128;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare outputs with the sample driven two negedges earlier
    task automatic check_outputs();
        bit    exp_v;
        string vtag;
        exp_v = h1_v && (h1_i >= PRIME);
        if (!h1_v)             vtag = "R9 idle gap";
        else if (h1_i < 0)     vtag = "R8 before first sof";
        else if (h1_i < PRIME) vtag = "R1 priming";
        else                   vtag = "R6 latency";
        chk(rv == exp_v, {vtag, " replicate valid"}, int'(rv), int'(exp_v));
        chk(zv == exp_v, {vtag, " zero valid"}, int'(zv), int'(exp_v));
        if (exp_v) begin
            int ci, f, r, c;
            bit interior;
            ci = h1_i - PRIME;
            f  = ci / (W * H);
            r  = (ci % (W * H)) / W;
            c  = ci % W;
            interior = (r >= 2 && r <= H - 3 && c >= 2 && c <= W - 3);
            n_out++;
            if (interior) begin
                chk(int'(rdata) == ref_out(f, r, c, 0),
                    (f == 0) ? "R3 full-scale" : "R2 interior",
                    int'(rdata), ref_out(f, r, c, 0));
                chk(int'(zdata) == ref_out(f, r, c, 1),
                    (f == 0) ? "R3 full-scale" : "R2 interior",
                    int'(zdata), ref_out(f, r, c, 1));
            end else begin
                chk(int'(rdata) == ref_out(f, r, c, 0), "R4 replicate border",
                    int'(rdata), ref_out(f, r, c, 0));
                chk(int'(zdata) == ref_out(f, r, c, 1), "R5 zero border",
                    int'(zdata), ref_out(f, r, c, 1));
            end
            chk(rsof == (r == 0 && c == 0), "R7 out_sof", int'(rsof), int'(r == 0 && c == 0));
            chk(rsol == (c == 0), "R7 out_sol", int'(rsol), int'(c == 0));
            chk(zsof == (r == 0 && c == 0), "R7 zero out_sof", int'(zsof), int'(r == 0 && c == 0));
            chk(zsol == (c == 0), "R7 zero out_sol", int'(zsol), int'(c == 0));
        end
    endtask

    // One cycle: check outputs, then drive the next input
    task automatic step(bit v, bit sof, bit sol, int data, int idx);
        @(negedge clk);
        check_outputs();
        in_valid = v;
        in_sof   = sof;
        in_sol   = sol;
        in_data  = DW'(data);
        h1_v = h0_v; h1_i = h0_i;
        h0_v = v;    h0_i = idx;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rv == 1'b0 && rsof == 1'b0 && rsol == 1'b0, "R1 reset replicate", int'(rv), 0);
        chk(zv == 1'b0 && zsof == 1'b0 && zsol == 1'b0, "R1 reset zero", int'(zv), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rv == 1'b0, "R1 after reset", int'(rv), 0);

        // Junk samples before any frame start
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, 200 + k, -1);

        next_idx = 0;
        for (int f = 0; f < NF; f++) begin
            for (int r = 0; r < H; r++) begin
                for (int c = 0; c < W; c++) begin
                    if ((f == 2 || f == 3) && ((r * W + c) % 3 == 1))
                        step(1'b0, 1'b0, 1'b0, 77, -1);
                    step(1'b1, (r == 0 && c == 0), (c == 0), pix(f, r, c), next_idx);
                    next_idx++;
                    n_in++;
                end
            end
        end
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b0, 0, -1);

        chk(n_out == n_in - PRIME, "R10 output count", n_out, n_in - PRIME);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule